// File: doc/BRIEF.md
# Page-Mode Read Sequencer

This block runs read cycles on an external asynchronous memory that offers page-mode reads over an 8-bit data bus. For every request it decides whether the target byte lies in the page that is already open. When it does, the read strobe is held low for the short in-page time. When it does not, the strobe is held low for the long page-opening time.

A page counts as open only while the same chip select has stayed asserted since the last read. That read must also have shared every address bit above the in-page offset. Changing the chip select closes the page, and so does letting the request stream go idle (which releases the chip select). The page size, the long pulse length and the short pulse length are configuration inputs. There is no external wait input; page mode and a wait signal must not be combined.

A requester raises `req_rd` with an address and a chip-select index, and holds them steady until `rsp_valid` pulses. In the cycle after that pulse it either presents the next request, which keeps the chip select asserted, or drops `req_rd`.

Top module: `page_read_seq`

## Requirements
- R1: After reset, `mem_rd_n` is high, every `mem_cs_n` bit is high, `rsp_valid` is low, and no page is open, so the first read uses the long pulse.
- R2: A read that opens a page holds `mem_rd_n` low for exactly `cfg_long_len` consecutive cycles.
- R3: A read on the same chip select as the previous read, with equal address bits above the in-page offset and no release in between, holds `mem_rd_n` low for exactly `cfg_short_len` cycles. This holds whether or not its address follows the previous one in sequence.
- R4: The in-page offset is the low `cfg_page_code + 2` address bits: code 0 is 4 bytes, 1 is 8, 2 is 16 and 3 is 32. A read whose bits above that offset differ from the previous read uses the long pulse.
- R5: A read whose chip-select index differs from the previous read uses the long pulse, even when the upper address bits match.
- R6: When `req_rd` is low in the cycle after `rsp_valid`, all `mem_cs_n` bits go high from the following cycle on, and the next read uses the long pulse.
- R7: A configured pulse length of 0 gives a one-cycle strobe.
- R8: `rsp_data` carries the value of `mem_data` in the last cycle `mem_rd_n` is low. `rsp_valid` is high for exactly the one cycle after `mem_rd_n` rises.
- R9: At most one `mem_cs_n` bit is low at any time. While a read is in progress, bit `req_cs` is the low one. That bit stays low without a gap between back-to-back reads on the same chip select.
- R10: `mem_addr` equals the request address and is stable for every cycle `mem_rd_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_long_len | input | 6 | Page-opening strobe length in cycles (0 means 1) |
| cfg_short_len | input | 6 | In-page strobe length in cycles (0 means 1) |
| cfg_page_code | input | 2 | Page size code: bytes = 4 << code |
| req_rd | input | 1 | Read request, held until `rsp_valid` |
| req_addr | input | ADDR_W | Byte address of the request |
| req_cs | input | CS_W | Chip-select index of the request |
| rsp_valid | output | 1 | One-cycle read completion |
| rsp_data | output | 8 | Byte read |
| mem_addr | output | ADDR_W | External address bus |
| mem_data | input | 8 | External data bus |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_cs_n | output | NCS | Active-low chip selects, one per device |

## Verification
The assertions assume that the requester keeps `req_rd`, `req_addr` and `req_cs` steady from the moment it raises a request until `rsp_valid` is seen. They also assume that `req_cs` is below NCS and that the configuration inputs do not change during a read. The bench drives every input at a falling edge, and changes the request fields or configuration only while the block is idle or right after a completion. The bench's data-bus model returns a value that rises by one in each cycle the strobe stays low. A capture taken one cycle early or late therefore gives wrong read data.

// File: rtl/pgrd_pkg.sv
package pgrd_pkg;
    localparam int LEN_W       = 6;
    localparam int DQ_W        = 8;
    localparam int PG_CODE_W   = 2;
    localparam int PG_MIN_LOG2 = 2;

    typedef enum logic [1:0] {
        S_IDLE,
        S_PULSE,
        S_DONE,
        S_HOLD
    } seq_state_e;

    typedef logic [LEN_W-1:0]     pulse_len_t;
    typedef logic [PG_CODE_W-1:0] page_code_t;
    typedef logic [DQ_W-1:0]      dq_t;

    // a programmed length of zero still yields one strobe cycle
    function automatic pulse_len_t eff_len(pulse_len_t l);
        return (l == '0) ? pulse_len_t'(1) : l;
    endfunction

    // number of low address bits that select a byte inside one page
    function automatic int offset_bits(page_code_t c);
        return PG_MIN_LOG2 + int'(c);
    endfunction
endpackage

// File: rtl/pgrd_page_track.sv
module pgrd_page_track
    import pgrd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CS_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  page_code_t        page_code,
    input  logic [ADDR_W-1:0] chk_addr,
    input  logic [CS_W-1:0]   chk_cs,
    input  logic              load,
    input  logic              clear,
    output logic              hit
);
    logic              rec_valid;
    logic [ADDR_W-1:0] rec_addr;
    logic [CS_W-1:0]   rec_cs;
    logic [ADDR_W-1:0] upper_mask;

    always_comb begin
        for (int i = 0; i < ADDR_W; i++) begin
            upper_mask[i] = (i >= offset_bits(page_code));
        end
    end

    assign hit = rec_valid
              && (chk_cs == rec_cs)
              && (((chk_addr ^ rec_addr) & upper_mask) == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_valid <= 1'b0;
            rec_addr  <= '0;
            rec_cs    <= '0;
        end else if (clear) begin
            rec_valid <= 1'b0;
        end else if (load) begin
            rec_valid <= 1'b1;
            rec_addr  <= chk_addr;
            rec_cs    <= chk_cs;
        end
    end

    // R6: releasing the chip select leaves no open page behind
    p_clear_miss_r6: assert property (@(posedge clk) disable iff (rst)
        clear |=> !hit);
endmodule

// File: rtl/pgrd_pulse_timer.sv
module pgrd_pulse_timer
    import pgrd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  pulse_len_t len,
    output logic       active,
    output logic       last
);
    pulse_len_t cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            active <= 1'b1;
            cnt_q  <= eff_len(len) - pulse_len_t'(1);
        end else if (active) begin
            if (cnt_q == '0) begin
                active <= 1'b0;
            end else begin
                cnt_q <= cnt_q - pulse_len_t'(1);
            end
        end
    end

    assign last = active && (cnt_q == '0);

    // R7: a zero length must end the strobe after its first cycle
    p_zero_len_r7: assert property (@(posedge clk) disable iff (rst)
        (start && (len == '0)) |=> last);

    // R2: the final cycle always closes the strobe
    p_last_ends_r2: assert property (@(posedge clk) disable iff (rst)
        (last && !start) |=> !active);
endmodule

// File: rtl/pgrd_cs_decode.sv
module pgrd_cs_decode #(
    parameter int NCS  = 4,
    parameter int CS_W = 2
) (
    input  logic            en,
    input  logic [CS_W-1:0] idx,
    output logic [NCS-1:0]  cs_n
);
    for (genvar g = 0; g < NCS; g++) begin : g_sel
        assign cs_n[g] = !(en && (idx == CS_W'(g)));
    end
endmodule

// File: rtl/page_read_seq.sv
module page_read_seq
    import pgrd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int NCS    = 4,
    localparam int CS_W  = (NCS > 1) ? $clog2(NCS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [5:0]        cfg_long_len,
    input  logic [5:0]        cfg_short_len,
    input  logic [1:0]        cfg_page_code,
    input  logic              req_rd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CS_W-1:0]   req_cs,
    output logic              rsp_valid,
    output logic [7:0]        rsp_data,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_data,
    output logic              mem_rd_n,
    output logic [NCS-1:0]    mem_cs_n
);
    seq_state_e        st_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CS_W-1:0]   cs_q;
    dq_t               data_q;

    logic       start;
    logic       clear;
    logic       page_hit;
    logic       tmr_active;
    logic       tmr_last;
    pulse_len_t pick_len;

    assign start    = req_rd && ((st_q == S_IDLE) || (st_q == S_HOLD));
    assign clear    = (st_q == S_HOLD) && !req_rd;
    assign pick_len = page_hit ? cfg_short_len : cfg_long_len;

    pgrd_page_track #(.ADDR_W(ADDR_W), .CS_W(CS_W)) u_track (
        .clk       (clk),
        .rst       (rst),
        .page_code (cfg_page_code),
        .chk_addr  (req_addr),
        .chk_cs    (req_cs),
        .load      (start),
        .clear     (clear),
        .hit       (page_hit)
    );

    pgrd_pulse_timer u_timer (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .len    (pick_len),
        .active (tmr_active),
        .last   (tmr_last)
    );

    pgrd_cs_decode #(.NCS(NCS), .CS_W(CS_W)) u_csdec (
        .en   (st_q != S_IDLE),
        .idx  (cs_q),
        .cs_n (mem_cs_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= S_IDLE;
            addr_q <= '0;
            cs_q   <= '0;
            data_q <= '0;
        end else begin
            unique case (st_q)
                S_IDLE, S_HOLD: begin
                    if (req_rd) begin
                        st_q   <= S_PULSE;
                        addr_q <= req_addr;
                        cs_q   <= req_cs;
                    end else begin
                        st_q <= S_IDLE;
                    end
                end
                S_PULSE: begin
                    if (tmr_last) begin
                        data_q <= mem_data;
                        st_q   <= S_DONE;
                    end
                end
                S_DONE: st_q <= S_HOLD;
                default: st_q <= S_IDLE;
            endcase
        end
    end

    assign mem_addr  = addr_q;
    assign mem_rd_n  = (st_q != S_PULSE);
    assign rsp_valid = (st_q == S_DONE);
    assign rsp_data  = data_q;

    // R9: never more than one device selected
    p_one_cs_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~mem_cs_n));

    // R9: a strobe is never issued without a selected device
    p_rd_has_cs_r9: assert property (@(posedge clk) disable iff (rst)
        !mem_rd_n |-> !(&mem_cs_n));

    // R8: completion is a single-cycle pulse
    p_rsp_single_r8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R8: completion follows directly on the end of the strobe
    p_rsp_after_rd_r8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(!mem_rd_n));

    // R10: address held still across the whole strobe
    p_addr_stable_r10: assert property (@(posedge clk) disable iff (rst)
        (!mem_rd_n && $past(!mem_rd_n)) |-> $stable(mem_addr));

    // R2: the timer runs only while the strobe is low
    p_timer_sync_r2: assert property (@(posedge clk) disable iff (rst)
        tmr_active |-> !mem_rd_n);
endmodule

// File: tb/test_page_read_seq.sv
`timescale 1ns/1ps
module test_page_read_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  cfg_long_len  = 6'd5;
    logic [5:0]  cfg_short_len = 6'd2;
    logic [1:0]  cfg_page_code = 2'd1;
    logic        req_rd   = 1'b0;
    logic [15:0] req_addr = '0;
    logic [1:0]  req_cs   = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_data;
    logic [15:0] mem_addr;
    logic [7:0]  mem_data;
    logic        mem_rd_n;
    logic [3:0]  mem_cs_n;
    int          low_cnt = 0;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    page_read_seq #(.ADDR_W(16), .NCS(4)) i_page_read_seq (
        .clk(clk), .rst(rst),
        .cfg_long_len(cfg_long_len), .cfg_short_len(cfg_short_len),
        .cfg_page_code(cfg_page_code),
        .req_rd(req_rd), .req_addr(req_addr), .req_cs(req_cs),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_addr(mem_addr), .mem_data(mem_data),
        .mem_rd_n(mem_rd_n), .mem_cs_n(mem_cs_n)
    );

    // memory model: value shifts by one for each cycle the strobe is low
    always @(posedge clk) low_cnt <= mem_rd_n ? 0 : low_cnt + 1;
    assign mem_data = mem_rd_n ? 8'h00
                    : 8'((mem_addr[7:0] ^ mem_addr[15:8] ^ 8'h3C) + low_cnt);

    function automatic int eff(logic [5:0] l);
        return (l == 0) ? 1 : int'(l);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_read(input logic [15:0] a, input logic [1:0] c,
                           input bit exp_long, input bit keep,
                           input bit exp_held, input string req);
        int  lowc = 0;
        int  n = 0;
        bit  released = 1'b0;
        bit  addr_bad = 1'b0;
        bit  cs_bad = 1'b0;
        int  exp_n;
        logic [7:0] exp_d;
        exp_n = eff(exp_long ? cfg_long_len : cfg_short_len);
        exp_d = 8'((a[7:0] ^ a[15:8] ^ 8'h3C) + exp_n - 1);
        req_rd = 1'b1; req_addr = a; req_cs = c;
        forever begin
            @(negedge clk);
            n++;
            if (&mem_cs_n) released = 1'b1;
            if (!mem_rd_n) begin
                lowc++;
                if (mem_addr != a) addr_bad = 1'b1;
                if (mem_cs_n != ~(4'b0001 << c)) cs_bad = 1'b1;
            end
            if (rsp_valid || n > 300) break;
        end
        chk(lowc == exp_n, {req, " strobe length"}, lowc, exp_n);
        chk(rsp_data == exp_d, "R8 read data", rsp_data, exp_d);
        chk(!addr_bad, "R10 address during strobe", mem_addr, a);
        chk(!cs_bad, "R9 selected chip", mem_cs_n, 4'hF ^ (4'b0001 << c));
        if (exp_held) chk(!released, "R9 select held between reads", released, 0);
        if (!keep) req_rd = 1'b0;
    endtask

    task automatic idle(int k);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(mem_rd_n == 1'b1, "R1 strobe idle", mem_rd_n, 1);
        chk(mem_cs_n == 4'hF, "R1 selects idle", mem_cs_n, 15);
        chk(rsp_valid == 1'b0, "R1 no completion", rsp_valid, 0);
        do_read(16'h0101, 2'd0, 1'b1, 1'b0, 1'b0, "R1 first read long");
        idle(3);
    endtask

    task automatic t_in_page();
        cfg_page_code = 2'd1;
        do_read(16'h0101, 2'd0, 1'b1, 1'b1, 1'b0, "R2 page open");
        do_read(16'h0103, 2'd0, 1'b0, 1'b1, 1'b1, "R3 in page");
        do_read(16'h0107, 2'd0, 1'b0, 1'b1, 1'b1, "R3 non-sequential");
        do_read(16'h0100, 2'd0, 1'b0, 1'b0, 1'b1, "R3 backward");
        idle(3);
    endtask

    task automatic t_page_cross();
        cfg_page_code = 2'd1;
        do_read(16'h0107, 2'd1, 1'b1, 1'b1, 1'b0, "R4 open 8B");
        do_read(16'h0108, 2'd1, 1'b1, 1'b0, 1'b1, "R4 crossing 8B page");
        idle(3);
        cfg_page_code = 2'd3;
        do_read(16'h0200, 2'd1, 1'b1, 1'b1, 1'b0, "R4 open 32B");
        do_read(16'h021F, 2'd1, 1'b0, 1'b1, 1'b1, "R4 inside 32B page");
        do_read(16'h0220, 2'd1, 1'b1, 1'b0, 1'b1, "R4 crossing 32B page");
        idle(3);
        cfg_page_code = 2'd0;
        do_read(16'h0300, 2'd1, 1'b1, 1'b1, 1'b0, "R4 open 4B");
        do_read(16'h0304, 2'd1, 1'b1, 1'b0, 1'b1, "R4 crossing 4B page");
        idle(3);
        cfg_page_code = 2'd1;
    endtask

    task automatic t_cs_change();
        do_read(16'h0400, 2'd0, 1'b1, 1'b1, 1'b0, "R5 open cs0");
        do_read(16'h0400, 2'd2, 1'b1, 1'b1, 1'b0, "R5 other cs same page");
        do_read(16'h0401, 2'd0, 1'b1, 1'b0, 1'b0, "R5 back to cs0");
        idle(3);
    endtask

    task automatic t_release();
        do_read(16'h0500, 2'd3, 1'b1, 1'b0, 1'b0, "R6 open");
        idle(2);
        chk(mem_cs_n == 4'hF, "R6 select released", mem_cs_n, 15);
        chk(rsp_valid == 1'b0, "R8 single completion", rsp_valid, 0);
        do_read(16'h0501, 2'd3, 1'b1, 1'b0, 1'b0, "R6 reopen after release");
        idle(3);
    endtask

    task automatic t_zero_len();
        cfg_long_len = 6'd0; cfg_short_len = 6'd0;
        do_read(16'h0600, 2'd1, 1'b1, 1'b1, 1'b0, "R7 zero long");
        do_read(16'h0602, 2'd1, 1'b0, 1'b0, 1'b1, "R7 zero short");
        idle(3);
        cfg_long_len = 6'd1; cfg_short_len = 6'd3;
        do_read(16'h0700, 2'd2, 1'b1, 1'b1, 1'b0, "R2 long shorter than short");
        do_read(16'h0701, 2'd2, 1'b0, 1'b0, 1'b1, "R3 short longer than long");
        idle(3);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_in_page();
        t_page_cross();
        t_cs_change();
        t_release();
        t_zero_len();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            finish_run();
        end
    end
endmodule